// File: doc/BRIEF.md
# Signal Label Defect Monitor

This block watches the path signal label byte that arrives once per frame and reports two persistent defects. The unequipped defect means the label has stayed at zero. The label mismatch defect means the label equals neither the host-programmed expected value nor the fixed equipped-non-specific code 0x01. Both defects are filtered over a run of consecutive frames, so a single corrupted label cannot raise or drop either one.

A frame strobe qualifies the label byte. Frames that arrive with a zero label are never counted as mismatched. Each time a defect is entered, a sticky interrupt request bit is set. The host clears that bit by writing 1 to it and can mask it from the combined interrupt output. The extraction of the label from the overhead happens upstream and is not part of this block.

Top module: `sld_monitor`

## Requirements
- R1: `uneq_defect` rises on the strobe edge of the fifth consecutive frame whose label is 0x00.
- R2: `uneq_defect` falls on the strobe edge of the fifth consecutive frame whose label is nonzero.
- R3: A frame is a mismatch frame when its label is nonzero, differs from `exp_label`, and differs from 0x01. `slm_defect` rises on the strobe edge of the fifth consecutive mismatch frame.
- R4: A zero label is never a mismatch frame. A run of zero labels therefore never raises `slm_defect`, and `uneq_defect` and `slm_defect` are never high together.
- R5: `slm_defect` falls on the strobe edge of the fifth consecutive non-mismatch frame. A non-mismatch frame has a label that equals `exp_label`, equals 0x01, or is zero.
- R6: A frame whose condition matches the present defect state restarts the five-frame count for that defect.
- R7: Clock cycles without `frame_valid` change neither defect state nor either count.
- R8: `irq_status[0]` (unequipped) and `irq_status[1]` (mismatch) are set on the same edge at which the matching defect rises. They are not set when the defect falls.
- R9: Writing 1 in `irq_clr[i]` clears `irq_status[i]` on that edge. When a set and a clear arrive on the same edge, the set wins.
- R10: `irq_req` is high exactly when some `irq_status[i]` is 1 and `irq_mask[i]` is 0. The mask has no effect on `irq_status`.
- R11: After a synchronous active-low reset, both defects, all counts and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe marking a valid label |
| rx_label | input | 8 | Received path signal label |
| exp_label | input | 8 | Host-programmed expected label |
| irq_mask | input | 2 | Interrupt mask, 1 = masked (bit0 unequipped, bit1 mismatch) |
| irq_clr | input | 2 | Write-1-to-clear strobe for `irq_status` |
| uneq_defect | output | 1 | Unequipped defect state |
| slm_defect | output | 1 | Label mismatch defect state |
| irq_status | output | 2 | Sticky interrupt request bits |
| irq_req | output | 1 | Combined unmasked interrupt request |

## Verification
The defect states and the status bits are registered on the strobe edge of the frame that decides them. They are due one edge after the frame is driven, and `irq_req` follows combinationally from status and mask. The bench drives every input at the falling edge and holds it across exactly one rising edge. It samples the outputs at the next falling edge, so each comparison sees the result of exactly one frame or one clear write. Idle cycles inserted between frames are also checked at falling edges, which confirms that nothing moves without a strobe.

// File: rtl/sld_pkg.sv
// Package: shared types and constants for the signal label defect monitor.
// Assumes labels are compared as plain unsigned bytes.
package sld_pkg;
    // Bit positions of the interrupt sources in status, mask and clear vectors.
    localparam int unsigned IRQ_UNEQ = 0;
    localparam int unsigned IRQ_SLM  = 1;
    localparam int unsigned IRQ_NUM  = 2;

    // Per-frame classification result.
    typedef struct packed {
        logic zero;
        logic mismatch;
    } label_class_t;
endpackage

// File: rtl/sld_label_classify.sv
// Module: per-frame label classifier.
// Flags a zero label and a mismatch label (nonzero, not expected, not the
// equipped-non-specific code). Pure combinational; assumes inputs are stable
// while the frame strobe is high.
module sld_label_classify
    import sld_pkg::*;
#(
    parameter int unsigned LABEL_W    = 8,
    parameter logic [LABEL_W-1:0] EQUIP_CODE = LABEL_W'(1)
) (
    input  logic [LABEL_W-1:0] label,
    input  logic [LABEL_W-1:0] expected,
    output label_class_t       cls
);
    localparam logic [LABEL_W-1:0] ZERO_LABEL = '0;

    // Classify the label; a zero label is never a mismatch.
    always_comb begin
        cls.zero     = (label == ZERO_LABEL);
        cls.mismatch = (label != ZERO_LABEL) &&
                       (label != expected)   &&
                       (label != EQUIP_CODE);
    end

    // R4: a zero label is never reported as a mismatch.
    always_comb begin
        a_r4_zero_not_mismatch: assert (!(cls.zero && cls.mismatch))
            else $error("zero label classified as mismatch");
    end
endmodule

// File: rtl/sld_persist_filter.sv
// Module: persistence filter for one defect.
// The state flips only after N_FRAMES consecutive strobed frames whose
// condition differs from the current state. A strobed frame that agrees
// with the state restarts the count. Assumes one strobe per frame.
module sld_persist_filter #(
    parameter int unsigned N_FRAMES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic cond,
    output logic state,
    output logic enter
);
    localparam int unsigned CNT_W = $clog2(N_FRAMES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_FRAMES - 1);

    logic             state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             differs;
    logic             hit;

    // Decide whether this frame extends the run and whether it completes it.
    always_comb begin
        differs = strobe && (cond != state_q);
        hit     = differs && (cnt_q == LAST);
    end

    // Update the run count and flip the state when the run completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= 1'b0;
            cnt_q   <= '0;
        end else if (strobe) begin
            if (hit) begin
                state_q <= cond;
                cnt_q   <= '0;
            end else if (differs) begin
                cnt_q   <= cnt_q + 1'b1;
            end else begin
                cnt_q   <= '0;
            end
        end
    end

    assign state = state_q;
    assign enter = hit && cond;

    // R7: without a strobe the state and count hold.
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(state_q) && $stable(cnt_q)))
        else $error("filter moved without strobe");

    // R6: the run count never reaches the persistence length.
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(N_FRAMES))
        else $error("run count out of range");

    // R6: a strobed frame that agrees with the state leaves the count at zero.
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (cond == state_q)) |=> (cnt_q == '0))
        else $error("run count not restarted");
endmodule

// File: rtl/sld_irq_bank.sv
// Module: sticky interrupt request bits with write-1-to-clear and masking.
// Set has priority over a clear on the same edge. Assumes set pulses last
// one cycle.
module sld_irq_bank #(
    parameter int unsigned N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set,
    input  logic [N_SRC-1:0] clr,
    input  logic [N_SRC-1:0] mask,
    output logic [N_SRC-1:0] status,
    output logic             req
);
    logic [N_SRC-1:0] status_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        // Hold, set or clear one sticky bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else if (set[i]) begin
                status_q[i] <= 1'b1;
            end else if (clr[i]) begin
                status_q[i] <= 1'b0;
            end
        end

        // R9: a clear without a simultaneous set empties the bit.
        a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !status_q[i])
            else $error("status bit not cleared");

        // R9: a set always leaves the bit high.
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> status_q[i])
            else $error("status bit not set");
    end

    // Combine the unmasked requests into one output.
    always_comb begin
        req = |(status_q & ~mask);
    end

    assign status = status_q;
endmodule

// File: rtl/sld_monitor.sv
// Module: signal label defect monitor (top).
// Classifies the label of each strobed frame and filters the unequipped and
// mismatch conditions over PERSIST_FRAMES frames. It raises sticky
// interrupt bits on defect entry. Assumes the expected label is stable
// across frames.
module sld_monitor
    import sld_pkg::*;
#(
    parameter int unsigned LABEL_W        = 8,
    parameter int unsigned PERSIST_FRAMES = 5,
    parameter logic [LABEL_W-1:0] EQUIP_CODE = LABEL_W'(1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_valid,
    input  logic [LABEL_W-1:0] rx_label,
    input  logic [LABEL_W-1:0] exp_label,
    input  logic [1:0]         irq_mask,
    input  logic [1:0]         irq_clr,
    output logic               uneq_defect,
    output logic               slm_defect,
    output logic [1:0]         irq_status,
    output logic               irq_req
);
    label_class_t       cls;
    logic [IRQ_NUM-1:0] enter;

    sld_label_classify #(
        .LABEL_W    (LABEL_W),
        .EQUIP_CODE (EQUIP_CODE)
    ) i_classify (
        .label    (rx_label),
        .expected (exp_label),
        .cls      (cls)
    );

    sld_persist_filter #(
        .N_FRAMES (PERSIST_FRAMES)
    ) i_uneq_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (frame_valid),
        .cond   (cls.zero),
        .state  (uneq_defect),
        .enter  (enter[IRQ_UNEQ])
    );

    sld_persist_filter #(
        .N_FRAMES (PERSIST_FRAMES)
    ) i_slm_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (frame_valid),
        .cond   (cls.mismatch),
        .state  (slm_defect),
        .enter  (enter[IRQ_SLM])
    );

    sld_irq_bank #(
        .N_SRC (IRQ_NUM)
    ) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (enter),
        .clr    (irq_clr),
        .mask   (irq_mask),
        .status (irq_status),
        .req    (irq_req)
    );

    // R4: the two defects exclude each other.
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(uneq_defect && slm_defect))
        else $error("both defects active");

    // R8: the unequipped status bit rises only together with its defect.
    a_r8_uneq_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[IRQ_UNEQ]) |-> $rose(uneq_defect))
        else $error("unequipped irq without defect entry");

    // R8: the mismatch status bit rises only together with its defect.
    a_r8_slm_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[IRQ_SLM]) |-> $rose(slm_defect))
        else $error("mismatch irq without defect entry");

    // R3: the mismatch defect only rises after a strobed frame.
    a_r3_slm_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slm_defect) |-> $past(frame_valid))
        else $error("mismatch defect rose without a frame");
endmodule

// File: tb/test_sld_monitor.sv
`timescale 1ns/1ps
module test_sld_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_valid = 1'b0;
    logic [7:0] rx_label = 8'h00;
    logic [7:0] exp_label = 8'h3C;
    logic [1:0] irq_mask = 2'b00;
    logic [1:0] irq_clr = 2'b00;
    logic       uneq_defect, slm_defect, irq_req;
    logic [1:0] irq_status;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference state.
    bit       m_uneq, m_slm;
    int       m_cu, m_cs;
    bit [1:0] m_stat;

    always #2.5 clk = ~clk;

    sld_monitor i_sld_monitor (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .rx_label    (rx_label),
        .exp_label   (exp_label),
        .irq_mask    (irq_mask),
        .irq_clr     (irq_clr),
        .uneq_defect (uneq_defect),
        .slm_defect  (slm_defect),
        .irq_status  (irq_status),
        .irq_req     (irq_req)
    );

    function automatic bit f_zero(input logic [7:0] l);
        return l == 8'h00;
    endfunction

    function automatic bit f_mis(input logic [7:0] l, input logic [7:0] e);
        return (l != 8'h00) && (l != e) && (l != 8'h01);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " uneq_defect"}, uneq_defect, m_uneq);
        chk({req, " slm_defect"}, slm_defect, m_slm);
        chk({req, " irq_status"}, irq_status, m_stat);
        chk({req, " R10 irq_req"}, irq_req, |(m_stat & ~irq_mask));
    endtask

    // Advance the reference model by one frame plus an optional clear.
    task automatic model_step(input bit fv, input logic [7:0] l, input bit [1:0] clr);
        bit [1:0] setv = 2'b00;
        if (fv) begin
            if (f_zero(l) != m_uneq) begin
                m_cu++;
                if (m_cu == 5) begin m_uneq = f_zero(l); m_cu = 0; if (m_uneq) setv[0] = 1; end
            end else m_cu = 0;
            if (f_mis(l, exp_label) != m_slm) begin
                m_cs++;
                if (m_cs == 5) begin m_slm = f_mis(l, exp_label); m_cs = 0; if (m_slm) setv[1] = 1; end
            end else m_cs = 0;
        end
        m_stat = (m_stat & ~clr) | setv;
    endtask

    // One cycle of stimulus: driven at negedge, sampled at the next negedge.
    task automatic cycle(input bit fv, input logic [7:0] l, input bit [1:0] clr);
        frame_valid = fv;
        rx_label    = l;
        irq_clr     = clr;
        @(posedge clk);
        @(negedge clk);
        frame_valid = 1'b0;
        irq_clr     = 2'b00;
        model_step(fv, l, clr);
    endtask

    task automatic frames(input logic [7:0] l, input int n);
        for (int i = 0; i < n; i++) cycle(1'b1, l, 2'b00);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A1D_0C2E));
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_uneq = 0; m_slm = 0; m_cu = 0; m_cs = 0; m_stat = 0;
        check_all("R11 reset");

        // R1: four zeros do not declare, the fifth does (R8 sets bit0).
        frames(8'h00, 4);
        chk("R1 four zeros", uneq_defect, 0);
        frames(8'h00, 1);
        chk("R1 fifth zero", uneq_defect, 1);
        chk("R8 uneq status", irq_status, 2'b01);
        chk("R4 no slm on zeros", slm_defect, 0);
        // R7: idle cycles change nothing.
        cycle(1'b0, 8'h77, 2'b00); cycle(1'b0, 8'h77, 2'b00);
        check_all("R7 idle");
        // R10: mask hides request, status kept.
        irq_mask = 2'b01;
        #0 check_all("R10 masked");
        irq_mask = 2'b00;
        // R9: clear.
        cycle(1'b0, 8'h00, 2'b01);
        chk("R9 clear uneq", irq_status, 2'b00);
        // R6: broken exit run restarts.
        frames(8'h3C, 4); frames(8'h00, 1); frames(8'h3C, 4);
        chk("R6 restart uneq exit", uneq_defect, 1);
        frames(8'h3C, 1);
        chk("R2 fifth nonzero", uneq_defect, 0);
        chk("R8 no irq on exit", irq_status, 2'b00);
        // R3: mismatch entry, broken by 0x01 once.
        frames(8'h55, 3); frames(8'h01, 1); frames(8'h55, 4);
        chk("R6 restart slm entry", slm_defect, 0);
        // Set and clear on same edge: set wins (R9).
        frame_valid = 1; rx_label = 8'h55; irq_clr = 2'b10;
        @(posedge clk); @(negedge clk);
        frame_valid = 0; irq_clr = 0;
        model_step(1'b1, 8'h55, 2'b10);
        chk("R3 slm declared", slm_defect, 1);
        chk("R9 set wins", irq_status[1], 1);
        // R5/R4: zeros exit mismatch and enter unequipped together.
        frames(8'h00, 5);
        chk("R5 slm exit by zeros", slm_defect, 0);
        chk("R1 uneq after zeros", uneq_defect, 1);
        check_all("R4 directed");

        // Constrained random runs.
        for (int r = 0; r < 300; r++) begin
            int kind = $urandom % 4;
            int len  = 1 + ($urandom % 7);
            if (($urandom % 5) == 0) irq_mask = 2'($urandom);
            for (int k = 0; k < len; k++) begin
                logic [7:0] l;
                case (kind)
                    0: l = 8'h00;
                    1: l = 8'h01;
                    2: l = exp_label;
                    default: begin
                        l = 8'($urandom);
                        if (l == 8'h00 || l == 8'h01 || l == exp_label) l = 8'hA5;
                    end
                endcase
                if (($urandom % 4) == 0) begin
                    cycle(1'b0, 8'($urandom), 2'b00);
                    check_all("R7 random idle");
                end
                cycle(1'b1, l, (($urandom % 6) == 0) ? 2'($urandom) : 2'b00);
                check_all("R3 R5 random");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule